// File: doc/BRIEF.md
# Video frame dimension checker

This block sits beside a pixel stream and confirms that every frame has the size software asked for. The stream carries a start-of-frame pulse, an end-of-frame pulse, a line-valid level and a per-beat valid. Between the two frame pulses the block counts units per line and completed lines per frame. A unit is one pixel, or one byte in byte mode, where each beat adds a programmed number of bits. Each finished line and each finished frame is compared with the expected width and height held in a register. A mismatch sets a sticky error bit. There is one bit for a wrong line width and one for a wrong line count, and the pair drives a masked interrupt.

At every end-of-frame the measured height, and the width of the last line, are latched into a status register. Software can therefore read the expected size and the actual size side by side when an interrupt arrives. Measurement is held off when the expected height is 1, and releasing the path switches both counters off.

Top module: `frame_dim_checker`

## Requirements
- R1: After reset the control, expected-size, measured-size, error-status and mask registers all read 0, and `irq` is low.
- R2: Address 0 holds the expected size: height in bits 31:16 and width in bits 15:0. It reads back exactly what was written.
- R3: Address 1 is the control register. Bit 0 enables the width (unit) check and bit 1 enables the line-count check. Bit 2 selects byte mode. Bits 6:4 select bits per pixel: codes 0..6 mean 6, 8, 10, 12, 14, 16 and 20. The register reads back what was written.
- R4: A beat is one cycle with `line_valid` and `pix_valid` both high inside a frame. When `line_valid` falls, the unit count of that line is compared with the expected width if bit 0 is set. A mismatch sets error-status bit 0 (address 3) at the same clock edge.
- R5: In byte mode the unit count of a line is ceil(beats × bits-per-pixel / 8).
- R6: At end-of-frame the number of completed lines is compared with the expected height if bit 1 is set. A mismatch sets error-status bit 1.
- R7: At end-of-frame, address 2 captures the line count in bits 31:16 and the unit count of the last line in bits 15:0.
- R8: While the expected height is 1, measurement is disarmed: no error bit is set and address 2 keeps its value.
- R9: Counts restart at start-of-frame. Beats and lines outside a start/end pair are ignored.
- R10: Unit and line counts saturate at 0xFFFF.
- R11: Error-status bits stay set until a 1 is written to them. `irq` is high when any status bit is set whose mask bit (address 4, bits 1:0) is also set.
- R12: A pulse on `path_release` clears control bits 0 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Register read data for `addr` |
| path_release | input | 1 | Switches both counters off |
| sof | input | 1 | Start-of-frame pulse |
| eof | input | 1 | End-of-frame pulse |
| line_valid | input | 1 | High for the duration of a line |
| pix_valid | input | 1 | Beat qualifier inside a line |
| irq | output | 1 | Masked error interrupt |

## Verification
The hardest case to reach from the ports is counter saturation. A single line has to carry more than 65535 beats before the width field pins at 0xFFFF. The stimulus drives one 70000-beat line against an expected width of 0xFFFF, so the saturated count must compare equal while the line count still mismatches. The other cases are driven by the scoreboard as whole frames:
- stalls in the middle of a line;
- stray lines before and after a frame;
- an expected height of 1;
- byte mode at three pixel depths.

For each frame the bench predicts the latched size and the error bits.

// File: rtl/fdc_pkg.sv
package fdc_pkg;

  // field width inside the 32-bit size words (height high, width low)
  localparam int FLD_W   = 16;
  localparam int ADDR_W  = 3;
  localparam int NUM_ERR = 2;
  localparam int ERR_PIX  = 0;
  localparam int ERR_LINE = 1;

  typedef enum logic [ADDR_W-1:0] {
    REG_EXPECT = 3'd0,
    REG_CTRL   = 3'd1,
    REG_MEAS   = 3'd2,
    REG_STAT   = 3'd3,
    REG_MASK   = 3'd4
  } reg_addr_e;

  // bits carried by one beat for each depth code
  function automatic logic [4:0] bpp_of(input logic [2:0] code);
    case (code)
      3'd0:    bpp_of = 5'd6;
      3'd1:    bpp_of = 5'd8;
      3'd2:    bpp_of = 5'd10;
      3'd3:    bpp_of = 5'd12;
      3'd4:    bpp_of = 5'd14;
      3'd5:    bpp_of = 5'd16;
      3'd6:    bpp_of = 5'd20;
      default: bpp_of = 5'd8;
    endcase
  endfunction

endpackage

// File: rtl/fdc_regs.sv
module fdc_regs
  import fdc_pkg::*;
#(
  parameter int DIM_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [31:0]          wdata,
  input  logic                 path_release,
  input  logic [NUM_ERR-1:0]   err_set,
  input  logic                 meas_load,
  input  logic [DIM_W-1:0]     meas_h,
  input  logic [DIM_W-1:0]     meas_w,
  output logic [31:0]          rdata,
  output logic [DIM_W-1:0]     exp_h,
  output logic [DIM_W-1:0]     exp_w,
  output logic                 pix_en,
  output logic                 line_en,
  output logic                 byte_mode,
  output logic [2:0]           bpp_code,
  output logic [NUM_ERR-1:0]   err_st,
  output logic [NUM_ERR-1:0]   err_mask,
  output logic [DIM_W-1:0]     meas_h_q,
  output logic [DIM_W-1:0]     meas_w_q,
  output logic                 irq
);

  logic we_exp, we_ctrl, we_stat, we_mask;
  logic [DIM_W-1:0]   exp_h_nxt, exp_w_nxt, mh_nxt, mw_nxt;
  logic               pix_en_nxt, line_en_nxt, byte_nxt;
  logic [2:0]         bpp_nxt;
  logic [NUM_ERR-1:0] st_nxt, mask_nxt;

  assign we_exp  = wr_en && (addr == REG_EXPECT);
  assign we_ctrl = wr_en && (addr == REG_CTRL);
  assign we_stat = wr_en && (addr == REG_STAT);
  assign we_mask = wr_en && (addr == REG_MASK);

  always_comb begin
    exp_h_nxt   = we_exp  ? wdata[FLD_W +: DIM_W] : exp_h;
    exp_w_nxt   = we_exp  ? wdata[0 +: DIM_W]     : exp_w;
    pix_en_nxt  = we_ctrl ? wdata[0] : pix_en;
    line_en_nxt = we_ctrl ? wdata[1] : line_en;
    byte_nxt    = we_ctrl ? wdata[2] : byte_mode;
    bpp_nxt     = we_ctrl ? wdata[6:4] : bpp_code;
    if (path_release) begin
      pix_en_nxt  = 1'b0;
      line_en_nxt = 1'b0;
    end
    mask_nxt = we_mask ? wdata[NUM_ERR-1:0] : err_mask;
    mh_nxt   = meas_load ? meas_h : meas_h_q;
    mw_nxt   = meas_load ? meas_w : meas_w_q;
  end

  // sticky status: a new error wins over a write-one-to-clear in the same cycle
  for (genvar gi = 0; gi < NUM_ERR; gi++) begin : g_err
    assign st_nxt[gi] = err_set[gi] | (err_st[gi] & ~(we_stat & wdata[gi]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_h     <= '0;
      exp_w     <= '0;
      pix_en    <= 1'b0;
      line_en   <= 1'b0;
      byte_mode <= 1'b0;
      bpp_code  <= '0;
      err_st    <= '0;
      err_mask  <= '0;
      meas_h_q  <= '0;
      meas_w_q  <= '0;
    end else begin
      exp_h     <= exp_h_nxt;
      exp_w     <= exp_w_nxt;
      pix_en    <= pix_en_nxt;
      line_en   <= line_en_nxt;
      byte_mode <= byte_nxt;
      bpp_code  <= bpp_nxt;
      err_st    <= st_nxt;
      err_mask  <= mask_nxt;
      meas_h_q  <= mh_nxt;
      meas_w_q  <= mw_nxt;
    end
  end

  assign irq = |(err_st & err_mask);

  always_comb begin
    rdata = '0;
    case (addr)
      REG_EXPECT: begin
        rdata[FLD_W +: DIM_W] = exp_h;
        rdata[0 +: DIM_W]     = exp_w;
      end
      REG_CTRL: begin
        rdata[0]   = pix_en;
        rdata[1]   = line_en;
        rdata[2]   = byte_mode;
        rdata[6:4] = bpp_code;
      end
      REG_MEAS: begin
        rdata[FLD_W +: DIM_W] = meas_h_q;
        rdata[0 +: DIM_W]     = meas_w_q;
      end
      REG_STAT: rdata[NUM_ERR-1:0] = err_st;
      REG_MASK: rdata[NUM_ERR-1:0] = err_mask;
      default:  rdata = '0;
    endcase
  end

endmodule

// File: rtl/fdc_line_meter.sv
module fdc_line_meter
  import fdc_pkg::*;
#(
  parameter int DIM_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sof,
  input  logic             active,
  input  logic             line_valid,
  input  logic             pix_valid,
  input  logic             byte_mode,
  input  logic [2:0]       bpp_code,
  output logic             line_end,
  output logic [DIM_W-1:0] line_units
);

  // bit accumulator: wide enough for a full DIM_W of 20-bit pixels
  localparam int AW = DIM_W + 5;
  localparam logic [AW-1:0]    ACC_MAX  = '1;
  localparam logic [DIM_W-1:0] UNIT_MAX = '1;

  logic [AW-1:0] acc_q, acc_nxt, base, step;
  logic [AW:0]   sum, units_full, bytes;
  logic          lv_q, lv_nxt, beat;

  assign beat     = active && line_valid && pix_valid;
  assign line_end = lv_q && !line_valid;
  assign step     = byte_mode ? {{(AW-5){1'b0}}, bpp_of(bpp_code)}
                              : {{(AW-1){1'b0}}, 1'b1};

  always_comb begin
    base    = (sof || line_end) ? '0 : acc_q;
    sum     = {1'b0, base} + {1'b0, step};
    acc_nxt = base;
    if (beat) acc_nxt = sum[AW] ? ACC_MAX : sum[AW-1:0];
    lv_nxt  = line_valid && active;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      lv_q  <= 1'b0;
    end else begin
      acc_q <= acc_nxt;
      lv_q  <= lv_nxt;
    end
  end

  // units of the line that is ending: beats, or bytes rounded up
  always_comb begin
    bytes      = ({1'b0, acc_q} + (AW+1)'(7)) >> 3;
    units_full = byte_mode ? bytes : {1'b0, acc_q};
    if (units_full > {{(AW+1-DIM_W){1'b0}}, UNIT_MAX}) line_units = UNIT_MAX;
    else                                               line_units = units_full[DIM_W-1:0];
  end

endmodule

// File: rtl/fdc_frame_meter.sv
module fdc_frame_meter
  import fdc_pkg::*;
#(
  parameter int DIM_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sof,
  input  logic               eof,
  input  logic               line_end,
  input  logic [DIM_W-1:0]   line_units,
  input  logic [DIM_W-1:0]   exp_h,
  input  logic [DIM_W-1:0]   exp_w,
  input  logic               pix_en,
  input  logic               line_en,
  output logic               active,
  output logic [NUM_ERR-1:0] err_set,
  output logic               meas_load,
  output logic [DIM_W-1:0]   meas_h,
  output logic [DIM_W-1:0]   meas_w
);

  localparam logic [DIM_W-1:0] CNT_MAX = '1;

  logic             in_frame_q, in_frame_nxt;
  logic [DIM_W-1:0] lines_q, lines_nxt, last_w_q, last_w_nxt, lines_now;
  logic             armed, eof_hit, line_done;

  assign active    = in_frame_q || sof;
  assign armed     = (pix_en || line_en) && (exp_h != DIM_W'(1));
  assign eof_hit   = eof && in_frame_q;
  assign line_done = line_end && in_frame_q;
  assign lines_now = (line_done && lines_q != CNT_MAX) ? lines_q + DIM_W'(1) : lines_q;

  always_comb begin
    in_frame_nxt = in_frame_q;
    if (eof) in_frame_nxt = 1'b0;
    if (sof) in_frame_nxt = 1'b1;
    lines_nxt  = sof ? '0 : lines_now;
    last_w_nxt = last_w_q;
    if (line_done) last_w_nxt = line_units;
    if (sof)       last_w_nxt = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame_q <= 1'b0;
      lines_q    <= '0;
      last_w_q   <= '0;
    end else begin
      in_frame_q <= in_frame_nxt;
      lines_q    <= lines_nxt;
      last_w_q   <= last_w_nxt;
    end
  end

  always_comb begin
    err_set           = '0;
    err_set[ERR_PIX]  = line_done && armed && pix_en && (line_units != exp_w);
    err_set[ERR_LINE] = eof_hit && armed && line_en && (lines_now != exp_h);
    meas_load         = eof_hit && armed;
    meas_h            = lines_now;
    meas_w            = line_done ? line_units : last_w_q;
  end

endmodule

// File: rtl/frame_dim_checker.sv
module frame_dim_checker
  import fdc_pkg::*;
#(
  parameter int DIM_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic              path_release,
  input  logic              sof,
  input  logic              eof,
  input  logic              line_valid,
  input  logic              pix_valid,
  output logic              irq
);

  logic [DIM_W-1:0]   exp_h, exp_w, meas_h, meas_w, meas_h_q, meas_w_q, line_units;
  logic               pix_en, line_en, byte_mode, active, line_end, meas_load;
  logic [2:0]         bpp_code;
  logic [NUM_ERR-1:0] err_set, err_st, err_mask;

  fdc_regs #(.DIM_W(DIM_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .path_release(path_release), .err_set(err_set), .meas_load(meas_load),
    .meas_h(meas_h), .meas_w(meas_w), .rdata(rdata), .exp_h(exp_h), .exp_w(exp_w),
    .pix_en(pix_en), .line_en(line_en), .byte_mode(byte_mode), .bpp_code(bpp_code),
    .err_st(err_st), .err_mask(err_mask), .meas_h_q(meas_h_q), .meas_w_q(meas_w_q),
    .irq(irq)
  );

  fdc_line_meter #(.DIM_W(DIM_W)) u_line (
    .clk(clk), .rst_n(rst_n), .sof(sof), .active(active), .line_valid(line_valid),
    .pix_valid(pix_valid), .byte_mode(byte_mode), .bpp_code(bpp_code),
    .line_end(line_end), .line_units(line_units)
  );

  fdc_frame_meter #(.DIM_W(DIM_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .sof(sof), .eof(eof), .line_end(line_end),
    .line_units(line_units), .exp_h(exp_h), .exp_w(exp_w), .pix_en(pix_en),
    .line_en(line_en), .active(active), .err_set(err_set), .meas_load(meas_load),
    .meas_h(meas_h), .meas_w(meas_w)
  );

endmodule

// File: rtl/fdc_checker.sv
module fdc_checker
  import fdc_pkg::*;
#(
  parameter int DIM_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wdata,
  input logic              path_release,
  input logic              eof,
  input logic              irq,
  input logic              pix_en,
  input logic              line_en,
  input logic [DIM_W-1:0]  exp_h,
  input logic [1:0]        err_st,
  input logic [1:0]        err_mask,
  input logic [DIM_W-1:0]  meas_h_q,
  input logic [DIM_W-1:0]  meas_w_q
);

  AST_PIX_ERR_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_st[0]) |-> $past(pix_en)); // R4

  AST_LINE_ERR_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_st[1]) |-> $past(line_en && exp_h != DIM_W'(1))); // R8

  AST_MEAS_AT_EOF: assert property (@(posedge clk) disable iff (!rst_n)
    !($stable(meas_h_q) && $stable(meas_w_q)) |-> $past(eof)); // R7

  AST_RELEASE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    path_release |=> (!pix_en && !line_en)); // R12

  AST_STICKY_PIX: assert property (@(posedge clk) disable iff (!rst_n)
    (err_st[0] && !(wr_en && addr == REG_STAT && wdata[0])) |=> err_st[0]); // R11

  AST_STICKY_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (err_st[1] && !(wr_en && addr == REG_STAT && wdata[1])) |=> err_st[1]); // R11

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    ((err_st & err_mask) == 2'b00) |-> !irq); // R11

endmodule

bind frame_dim_checker fdc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .path_release(path_release), .eof(eof), .irq(irq), .pix_en(pix_en),
  .line_en(line_en), .exp_h(exp_h), .err_st(err_st), .err_mask(err_mask),
  .meas_h_q(meas_h_q), .meas_w_q(meas_w_q)
);

// File: tb/frame_dim_checker_tb.sv
module frame_dim_checker_tb;
  import fdc_pkg::*;

  localparam time CLK_P = 20ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, path_release = 1'b0;
  logic sof = 1'b0, eof = 1'b0, line_valid = 1'b0, pix_valid = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic irq;

  int total = 0, bad = 0;

  typedef struct {
    logic [31:0] meas;
    logic [1:0]  st;
    logic        irq;
    string       req;
  } item_t;
  item_t sb[$];

  // bench model of the programmed state
  logic [31:0] m_ctrl = '0, m_exp = '0, m_meas = '0;
  logic [1:0]  m_mask = '0;
  bit          with_stall = 0;
  int          lw[$];

  always #(CLK_P/2) clk = ~clk;

  frame_dim_checker u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .path_release(path_release), .sof(sof), .eof(eof),
    .line_valid(line_valid), .pix_valid(pix_valid), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  function automatic int bpp_val(input logic [2:0] c);
    case (c)
      3'd0: return 6;   3'd1: return 8;   3'd2: return 10; 3'd3: return 12;
      3'd4: return 14;  3'd5: return 16;  3'd6: return 20; default: return 8;
    endcase
  endfunction

  function automatic int units_of(input int beats);
    int u;
    u = m_ctrl[2] ? (beats * bpp_val(m_ctrl[6:4]) + 7) / 8 : beats;
    return (u > 65535) ? 65535 : u;
  endfunction

  task automatic drive_line(input int w);
    for (int k = 0; k < w; k++) begin
      @(negedge clk); line_valid = 1'b1; pix_valid = 1'b1;
      if (with_stall && k == w/2) begin
        @(negedge clk); pix_valid = 1'b0;
      end
    end
    @(negedge clk); line_valid = 1'b0; pix_valid = 1'b0;
    @(negedge clk);
  endtask

  // driver: sends one frame of lw[] and pushes the predicted result
  task automatic run_frame(input string req);
    item_t it;
    bit armed, perr, lerr;
    int lastu, n;
    @(negedge clk); sof = 1'b1;
    @(negedge clk); sof = 1'b0;
    perr = 0; lastu = 0; n = lw.size();
    foreach (lw[i]) begin
      drive_line(lw[i]);
      lastu = units_of(lw[i]);
      if (lastu != int'(m_exp[15:0])) perr = 1;
    end
    @(negedge clk); eof = 1'b1;
    @(negedge clk); eof = 1'b0;
    armed = (m_ctrl[0] || m_ctrl[1]) && (m_exp[31:16] != 16'd1);
    lerr  = armed && m_ctrl[1] && (n != int'(m_exp[31:16]));
    perr  = armed && m_ctrl[0] && perr;
    if (armed) m_meas = {16'(n), 16'(lastu)};
    it.meas = m_meas;
    it.st   = {lerr, perr};
    it.irq  = |({lerr, perr} & m_mask);
    it.req  = req;
    sb.push_back(it);
    wait (sb.size() == 0);
    repeat (2) @(negedge clk);
  endtask

  task automatic stray_line(input int w);
    drive_line(w);
  endtask

  // monitor: pops predictions and compares them with the registers
  initial begin
    item_t it;
    logic [31:0] v;
    forever begin
      @(negedge clk);
      if (sb.size() > 0) begin
        it = sb[0];
        rd(REG_MEAS, v);
        chk(v == it.meas, {it.req, " R7 measured size"}, v, it.meas);
        rd(REG_STAT, v);
        chk(v[1:0] == it.st, {it.req, " error status"}, {30'd0, v[1:0]}, {30'd0, it.st});
        chk(irq == it.irq, {it.req, " R11 irq"}, {31'd0, irq}, {31'd0, it.irq});
        wr(REG_STAT, 32'h3);
        rd(REG_STAT, v);
        chk(v[1:0] == 2'b00, {it.req, " R11 write-one clears"}, v, 32'h0);
        void'(sb.pop_front());
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    chk(1'b0, "watchdog", 32'h0, 32'h1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic cfg(input logic [31:0] ctrl, input logic [31:0] expect_v);
    wr(REG_CTRL, ctrl);     m_ctrl = ctrl;
    wr(REG_EXPECT, expect_v); m_exp = expect_v;
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(REG_CTRL, v);   chk(v == 0, "R1 ctrl", v, 0);
    rd(REG_EXPECT, v); chk(v == 0, "R1 expect", v, 0);
    rd(REG_MEAS, v);   chk(v == 0, "R1 meas", v, 0);
    rd(REG_STAT, v);   chk(v == 0, "R1 status", v, 0);
    rd(REG_MASK, v);   chk(v == 0, "R1 mask", v, 0);
    chk(irq == 1'b0, "R1 irq", {31'd0, irq}, 0);

    cfg(32'h3, 32'h0003_0004);
    rd(REG_EXPECT, v); chk(v == 32'h0003_0004, "R2 readback", v, 32'h0003_0004);
    rd(REG_CTRL, v);   chk(v == 32'h3, "R3 readback", v, 32'h3);
    wr(REG_MASK, 32'h3); m_mask = 2'b11;

    with_stall = 1;
    lw = '{4, 4, 4}; run_frame("R4 R6 match with stalls");
    with_stall = 0;
    lw = '{4, 5, 4}; run_frame("R4 width mismatch");
    lw = '{4, 4};    run_frame("R6 line mismatch");

    // R5 byte mode at three depths
    cfg(32'h27, 32'h0003_0007); rd(REG_CTRL, v); chk(v == 32'h27, "R3 depth field", v, 32'h27);
    lw = '{5, 5, 5}; run_frame("R5 10-bit");
    cfg(32'h07, 32'h0002_0003);
    lw = '{3, 3};    run_frame("R5 6-bit");
    cfg(32'h67, 32'h0002_0008);
    lw = '{3, 3};    run_frame("R5 20-bit");

    // R11 masking
    cfg(32'h3, 32'h0003_0004);
    wr(REG_MASK, 32'h1); m_mask = 2'b01;
    lw = '{4, 4};    run_frame("R11 masked line error");
    wr(REG_MASK, 32'h3); m_mask = 2'b11;

    // R8 disarm at height 1
    cfg(32'h3, 32'h0001_0004);
    lw = '{9, 9};    run_frame("R8 disarmed");

    // R9 stray lines outside a frame
    cfg(32'h3, 32'h0002_0006);
    stray_line(7);
    lw = '{6, 6};    run_frame("R9 stray before");
    stray_line(3);
    lw = '{6, 6};    run_frame("R9 stray after");

    // R12 release
    @(negedge clk); path_release = 1'b1;
    @(negedge clk); path_release = 1'b0; m_ctrl[1:0] = 2'b00;
    rd(REG_CTRL, v); chk(v[1:0] == 2'b00, "R12 enables cleared", v, 0);
    lw = '{1, 1, 1}; run_frame("R12 released no check");

    // R10 saturation
    cfg(32'h3, 32'h0002_FFFF);
    lw = '{70000};   run_frame("R10 saturated width");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule